// File: doc/BRIEF.md
# Dual-Identity Two-Wire Slave Address Decoder

This block sits behind the pins of a two-wire serial slave that presents two targets on one bus: an I/O port and a memory. It cleans the sampled clock and data lines, watches for start and stop conditions, and collects the first byte after every start. That byte is compared against two 7-bit identities. Both share six bits strapped from board pins; they differ only in the top address bit, which is 0 for the port and 1 for the memory.

On a hit the block pulls the data line low for the acknowledge clock, latches which target was chosen together with the transfer direction, and then hands each following write byte to that target with a one-cycle strobe. Each write byte is acknowledged. A miss, or a memory hit while the memory reports busy, leaves the line released. All traffic is then ignored until the next start. A repeated start decodes afresh with no stop needed.

Top module: `dual_id_addr_decoder`

## Requirements
- R1: Each line passes a filter. A level on `scl_in` or `sda_in` reaches the decoder only after it has differed from the filtered value for FILT_LEN consecutive clocks (default 3). A pulse of FILT_LEN-1 clocks or less has no effect.
- R2: The address byte is shifted in MSB first. Bit 7 is the identity bit, bits 6..1 must equal `strap_addr[5:0]`, and bit 0 is the direction, with 1 meaning read and 0 meaning write.
- R3: A byte with bit 7 = 0 and a matching strap field sets `port_sel`. `ack_drive` is then high during the ninth clock.
- R4: A byte with bit 7 = 1 and a matching strap field sets `mem_sel` and is acknowledged the same way, provided `mem_busy` is low.
- R5: If `mem_busy` is high when the eighth address clock falls, a memory match gets no acknowledge and no select. The following bytes are ignored. A port match is not affected by `mem_busy`.
- R6: A byte matching neither identity produces no acknowledge, no select and no strobe for any later byte until the next start.
- R7: After an accepted address, `rd_nwr` equals address bit 0 until a start or stop.
- R8: In write direction, every later byte is presented on `rx_byte` with a one-cycle pulse on the strobe of the selected target only (`port_stb` or `mem_stb`), and it is acknowledged in its ninth clock.
- R9: In read direction, no strobes are produced and `ack_drive` stays low for data bytes.
- R10: A repeated start clears the selection and decodes the next byte as an address, with no stop in between.
- R11: A stop condition clears `port_sel`, `mem_sel`, `rd_nwr` and `ack_drive`.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| strap_addr | input | 6 | Board-strapped shared address bits |
| mem_busy | input | 1 | Memory cannot accept a new access |
| ack_drive | output | 1 | 1 pulls the data line low |
| port_sel | output | 1 | Port identity is selected |
| mem_sel | output | 1 | Memory identity is selected |
| rd_nwr | output | 1 | Direction of the selected transfer, 1 = read |
| port_stb | output | 1 | Write byte valid for the port |
| mem_stb | output | 1 | Write byte valid for the memory |
| rx_byte | output | 8 | Last write data byte received |

## Verification
The checks assume that `scl_in` and `sda_in` are already synchronous to `clk`, and that every intended bus level is held for well over FILT_LEN clocks. They also assume that data changes only while the clock line is low, except when it is deliberately forming a start or stop. The bench drives each half-period for six clocks and changes data only in the low phase. It breaks these rules on purpose only in the short glitch cases, where the filter is expected to hide the pulse. `mem_busy` and `strap_addr` are changed only while the bus is idle.

// File: rtl/dual_id_pkg.sv
package dual_id_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 6;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
  } dec_state_t;

  // Returns {memory hit, port hit} for an address byte against the strap.
  function automatic logic [1:0] id_match(input logic [BYTE_W-1:0] abyte,
                                          input logic [STRAP_W-1:0] strap);
    logic same;
    same = (abyte[BYTE_W-2:1] == strap);
    return {abyte[BYTE_W-1] & same, ~abyte[BYTE_W-1] & same};
  endfunction
endpackage

// File: rtl/line_spike_filter.sv
module line_spike_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic clean_out
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_out <= RST_VAL;
      run_cnt   <= '0;
    end else if (raw_in == clean_out) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      clean_out <= raw_in;
      run_cnt   <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_det = scl_q & scl_f & sda_q & ~sda_f;
  assign stop_det  = scl_q & scl_f & ~sda_q & sda_f;
  assign scl_rise  = ~scl_q & scl_f;
  assign scl_fall  = scl_q & ~scl_f;
endmodule

// File: rtl/addr_byte_fsm.sv
module addr_byte_fsm
  import dual_id_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_f,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               mem_busy,
  output logic               ack_drive,
  output logic               port_sel,
  output logic               mem_sel,
  output logic               rd_nwr,
  output logic               port_stb,
  output logic               mem_stb,
  output logic [BYTE_W-1:0]  rx_byte
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  dec_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [1:0]        hit;
  logic              take_port, take_mem, byte_full;

  assign hit       = id_match(shreg, strap_addr);
  assign take_port = hit[0];
  assign take_mem  = hit[1] & ~mem_busy;
  assign byte_full = (bit_cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ack_drive <= 1'b0;
      port_sel  <= 1'b0;
      mem_sel   <= 1'b0;
      rd_nwr    <= 1'b0;
      port_stb  <= 1'b0;
      mem_stb   <= 1'b0;
      rx_byte   <= '0;
    end else begin
      port_stb <= 1'b0;
      mem_stb  <= 1'b0;
      if (start_det || stop_det) begin
        state     <= start_det ? ST_ADDR : ST_IDLE;
        bit_cnt   <= '0;
        ack_drive <= 1'b0;
        port_sel  <= 1'b0;
        mem_sel   <= 1'b0;
        rd_nwr    <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise && !byte_full) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (take_port || take_mem) begin
                port_sel  <= take_port;
                mem_sel   <= take_mem;
                rd_nwr    <= shreg[0];
                ack_drive <= 1'b1;
                state     <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall) begin
              ack_drive <= 1'b0;
              bit_cnt   <= '0;
              state     <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (scl_rise && !byte_full) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST && !rd_nwr) begin
                rx_byte  <= {shreg[BYTE_W-2:0], sda_f};
                port_stb <= port_sel;
                mem_stb  <= mem_sel;
              end
            end else if (scl_fall && byte_full) begin
              ack_drive <= ~rd_nwr;
              state     <= ST_DATA_ACK;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_id_addr_decoder.sv
module dual_id_addr_decoder
  import dual_id_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               mem_busy,
  output logic               ack_drive,
  output logic               port_sel,
  output logic               mem_sel,
  output logic               rd_nwr,
  output logic               port_stb,
  output logic               mem_stb,
  output logic [BYTE_W-1:0]  rx_byte
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic scl_f, sda_f, start_det, stop_det, scl_rise, scl_fall;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    line_spike_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_in    (raw_lines[g]),
      .clean_out (clean_lines[g])
    );
  end

  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  bus_cond_detect u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  addr_byte_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_f      (sda_f),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_addr (strap_addr),
    .mem_busy   (mem_busy),
    .ack_drive  (ack_drive),
    .port_sel   (port_sel),
    .mem_sel    (mem_sel),
    .rd_nwr     (rd_nwr),
    .port_stb   (port_stb),
    .mem_stb    (mem_stb),
    .rx_byte    (rx_byte)
  );
endmodule

// File: rtl/dual_id_chk.sv
module dual_id_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic scl_f,
  input logic start_det,
  input logic stop_det,
  input logic mem_busy,
  input logic ack_drive,
  input logic port_sel,
  input logic mem_sel,
  input logic rd_nwr,
  input logic port_stb,
  input logic mem_stb
);
  // R1
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f) |-> (scl_f == $past(scl_in)));

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({port_sel, mem_sel}));

  // R5
  busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sel) |-> !$past(mem_busy));

  // R6
  ack_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> (port_sel || mem_sel));

  // R8
  stb_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_stb |-> (port_sel && !rd_nwr)) and (mem_stb |-> (mem_sel && !rd_nwr)));

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!port_sel && !mem_sel && !ack_drive));

  // R11
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!port_sel && !mem_sel && !ack_drive && !rd_nwr));
endmodule

bind dual_id_addr_decoder dual_id_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .scl_f     (scl_f),
  .start_det (start_det),
  .stop_det  (stop_det),
  .mem_busy  (mem_busy),
  .ack_drive (ack_drive),
  .port_sel  (port_sel),
  .mem_sel   (mem_sel),
  .rd_nwr    (rd_nwr),
  .port_stb  (port_stb),
  .mem_stb   (mem_stb)
);

// File: tb/dual_id_addr_decoder_tb.sv
module dual_id_addr_decoder_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [5:0] strap = 6'h2D;
  logic busy = 1'b0;
  logic ack_drive, port_sel, mem_sel, rd_nwr, port_stb, mem_stb;
  logic [7:0] rx_byte;
  logic sda_bus;

  int checks = 0, failures = 0, cyc = 0;
  int n_pstb = 0, n_mstb = 0;
  logic [7:0] last_p = 8'h00, last_m = 8'h00;
  logic s_ack, s_port, s_mem, s_rd;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~ack_drive;

  dual_id_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .strap_addr(strap), .mem_busy(busy), .ack_drive(ack_drive),
    .port_sel(port_sel), .mem_sel(mem_sel), .rd_nwr(rd_nwr),
    .port_stb(port_stb), .mem_stb(mem_stb), .rx_byte(rx_byte)
  );

  always @(negedge clk) begin
    if (port_stb) begin n_pstb++; last_p = rx_byte; end
    if (mem_stb)  begin n_mstb++; last_m = rx_byte; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    m_sda = b; hold(H);
    m_scl = 1'b1; hold(H / 2);
    s_ack = ack_drive; s_port = port_sel; s_mem = mem_sel; s_rd = rd_nwr;
    hold(H - H / 2);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
  endtask

  task automatic do_start;
    m_sda = 1'b1; m_scl = 1'b1; hold(H);
    m_sda = 1'b0; hold(H);
    m_scl = 1'b0; hold(H);
  endtask

  task automatic rep_start;
    m_sda = 1'b1; hold(H);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b0; hold(H);
    m_scl = 1'b0; hold(H);
  endtask

  task automatic do_stop;
    m_sda = 1'b0; hold(H);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b1; hold(2 * H);
  endtask

  // One address byte plus one data byte; expected values from the requirements.
  task automatic transact(input logic [7:0] a, input logic [7:0] d, input string tag);
    logic pe, me, any;
    int p0, m0;
    pe  = (a[7] == 1'b0) && (a[6:1] == strap);
    me  = (a[7] == 1'b1) && (a[6:1] == strap) && !busy;
    any = pe || me;
    do_start;
    send_byte(a);
    clock_bit(1'b1);
    chk({tag, " R3/R4/R6 addr ack"}, s_ack, any);
    chk({tag, " R3 port_sel"}, s_port, pe);
    chk({tag, " R4/R5 mem_sel"}, s_mem, me);
    if (any) chk({tag, " R7 rd_nwr"}, s_rd, a[0]);
    p0 = n_pstb; m0 = n_mstb;
    send_byte(a[0] ? 8'hFF : d);
    clock_bit(1'b1);
    chk({tag, " R8/R9 data ack"}, s_ack, any && !a[0]);
    hold(2);
    chk({tag, " R8/R9 port strobes"}, n_pstb - p0, (pe && !a[0]) ? 1 : 0);
    chk({tag, " R8/R9 mem strobes"}, n_mstb - m0, (me && !a[0]) ? 1 : 0);
    if (pe && !a[0]) chk({tag, " R8 port byte"}, last_p, d);
    if (me && !a[0]) chk({tag, " R8 mem byte"}, last_m, d);
    do_stop;
    chk({tag, " R11 cleared after stop"}, {port_sel, mem_sel, rd_nwr, ack_drive}, 4'b0);
  endtask

  initial begin
    hold(3);
    chk("R12 reset outputs", {ack_drive, port_sel, mem_sel, rd_nwr, port_stb, mem_stb, rx_byte}, 14'h0);
    rst_n = 1'b1;
    hold(4);
    chk("R12 after release", {ack_drive, port_sel, mem_sel, rd_nwr}, 4'h0);

    // R2/R3/R4/R6/R7/R8/R9: full sweep of address bytes for one strap
    for (int a = 0; a < 256; a++) transact(8'(a), 8'(a) ^ 8'h5A, "sweep");

    // R2: other strap values
    strap = 6'h3F;
    transact(8'h7E, 8'hC3, "strap3F port");
    transact(8'h7C, 8'hC3, "strap3F miss");
    transact(8'hFF, 8'h00, "strap3F memrd");
    strap = 6'h00;
    transact(8'h80, 8'h81, "strap00 mem");
    transact(8'h00, 8'h7F, "strap00 port");
    strap = 6'h2D;

    // R5: busy memory is refused, port still served
    busy = 1'b1;
    transact({1'b1, 6'h2D, 1'b0}, 8'h33, "R5 busy memwr");
    transact({1'b1, 6'h2D, 1'b1}, 8'h33, "R5 busy memrd");
    transact({1'b0, 6'h2D, 1'b0}, 8'h44, "R5 busy portwr");
    busy = 1'b0;

    // R10: repeated start from a port write to a memory write
    begin
      int m0;
      do_start;
      send_byte({1'b0, 6'h2D, 1'b0}); clock_bit(1'b1);
      send_byte(8'h12); clock_bit(1'b1);
      rep_start;
      chk("R10 sel cleared by repeated start", {port_sel, mem_sel}, 2'b00);
      m0 = n_mstb;
      send_byte({1'b1, 6'h2D, 1'b0}); clock_bit(1'b1);
      chk("R10 ack after repeated start", s_ack, 1'b1);
      chk("R10 mem_sel after repeated start", {s_port, s_mem}, 2'b01);
      send_byte(8'hE7); clock_bit(1'b1);
      hold(2);
      chk("R10 mem strobe", n_mstb - m0, 1);
      chk("R10 mem byte", last_m, 8'hE7);
      do_stop;
    end

    // R10/R6: miss, then repeated start to a matching port address
    do_start;
    send_byte(8'h11); clock_bit(1'b1);
    chk("R6 miss no ack", s_ack, 1'b0);
    rep_start;
    send_byte({1'b0, 6'h2D, 1'b1}); clock_bit(1'b1);
    chk("R10 ack after miss", s_ack, 1'b1);
    chk("R7 read after repeated start", s_rd, 1'b1);
    do_stop;

    // R1: short data glitch while clock high must not form a start
    m_sda = 1'b0; hold(2); m_sda = 1'b1; hold(2 * H);
    m_scl = 1'b0; hold(H);
    send_byte({1'b0, 6'h2D, 1'b0}); clock_bit(1'b1);
    chk("R1 no start from glitch", {s_ack, s_port}, 2'b00);
    do_stop;

    // R1: short clock glitch inside a data byte must not add a bit
    begin
      int p0;
      logic [7:0] d;
      d = 8'hB6;
      do_start;
      send_byte({1'b0, 6'h2D, 1'b0}); clock_bit(1'b1);
      p0 = n_pstb;
      for (int i = 7; i >= 0; i--) begin
        if (i == 4) begin
          m_sda = d[i]; hold(2);
          m_scl = 1'b1; hold(2); m_scl = 1'b0; hold(2);
        end
        clock_bit(d[i]);
      end
      clock_bit(1'b1);
      hold(2);
      chk("R1 clock glitch strobe count", n_pstb - p0, 1);
      chk("R1 clock glitch byte", last_p, d);
      do_stop;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule